// File: doc/BRIEF.md
# Burst Read Path Controller

This block sits between a processor-bus slave port and the user interface of a DDR memory controller and serves read requests. A fill state machine turns each accepted request into one or more 16-byte memory commands and writes the returned words into a small read FIFO. A separate drain stage empties that FIFO toward the bus slave. It raises a read acknowledge for each word, and the word follows on the data output one cycle later. Because the two sides meet only at the FIFO, words go back to the bus while later words of the same burst are still arriving from memory.

Single-word reads and bursts of up to 128 bytes are supported. Every command targets a 16-byte-aligned quad. A single read fetches one quad and keeps only the addressed word. Before each command, a one-cycle advance notice tells the surrounding logic that a command and address are due on the next cycle. The block uses one clock. Any crossing into a faster memory clock belongs to a wrapper.

Top module: `rdpath_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `cmd_pending`, `mc_cmd_valid` and `rd_ack` are 0, and `burst_count` and `bus_rd_data` are 0.
- R2: A request is accepted only in a cycle where `bus_sel`, `bus_rd_nwr` and `bus_rd_req` are all 1. With any of them 0, no command notice is raised.
- R3: Each `mc_cmd_valid` pulse lasts one cycle, and `cmd_pending` is high in exactly the cycle before it. There is one notice per command.
- R4: A burst (`bus_burst`=1) issues N commands, where N is `bus_burst_bytes` divided by 16 with the remainder dropped. N=0 is treated as 1, and N above 8 is treated as 8. The first command address is `bus_addr` with bits [3:0] cleared, and each following address is 16 higher.
- R5: A single read (`bus_burst`=0) issues one command at `bus_addr` with bits [3:0] cleared. Of the four 32-bit words returned, only the word with index `bus_addr[3:2]` (0 = first beat) is delivered, with exactly one acknowledge.
- R6: Data words are taken from `mc_rd_data` only in cycles where `mc_rd_valid` is 1 while a command is outstanding. A valid strobe with no command outstanding produces no acknowledge and no change to `burst_count`.
- R7: After each cycle with `rd_ack`=1, the next word is on `bus_rd_data` in the following cycle. Words are delivered in the order they arrived. `bus_rd_data` changes only in a cycle that follows an acknowledge.
- R8: A word captured at a clock edge is acknowledged in the cycle right after that edge. Acknowledges are issued back to back, one per cycle, while words remain, so they overlap with the arrival of later beats.
- R9: `burst_count` is cleared when a request is accepted, rises by one for each word placed in the FIFO, and holds its final value until the next acceptance.
- R10: The memory controller's address almost-full input has no effect. A burst completes identically with it held at 1.
- R11: After a request's last word has been captured, no new request is accepted until the request combination has been seen low at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus slave select for this memory |
| bus_rd_nwr | input | 1 | 1 = read access |
| bus_rd_req | input | 1 | Read request, held until the last word is returned |
| bus_addr | input | ADDR_W | Byte address of the read |
| bus_burst | input | 1 | 1 = burst read, 0 = single word |
| bus_burst_bytes | input | LEN_W | Burst length in bytes |
| mc_addr_almost_full | input | 1 | Memory controller command-queue almost full (ignored) |
| mc_rd_valid | input | 1 | Memory controller read data strobe |
| mc_rd_data | input | DATA_W | Memory controller read data |
| cmd_pending | output | 1 | A command and address are due on the next cycle |
| mc_cmd_valid | output | 1 | Read command to the memory controller |
| mc_cmd_addr | output | ADDR_W | 16-byte-aligned command address |
| rd_ack | output | 1 | Read acknowledge; the word is valid next cycle |
| bus_rd_data | output | DATA_W | Read data returned to the bus slave |
| burst_count | output | CNT_W | Words captured for the current request |

## Verification
The assertions assume that the memory controller returns exactly four strobed beats for each command and only after that command has been issued. They also assume that the requester keeps its request up until the last word has come back and then lowers it. The bench's memory model answers each command after a fixed two-cycle latency with four beats, sometimes with a one-cycle hole between beats. Stray strobes are injected only while no command is outstanding. Each directed read keeps its request up until the expected number of words has been observed, and only then lowers it.

// File: rtl/rdpath_pkg.sv
package rdpath_pkg;
  localparam int unsigned QUAD_BYTES = 16;
  localparam int unsigned QUAD_LSB   = 4;

  typedef enum logic [2:0] {
    F_IDLE,
    F_ANNOUNCE,
    F_ISSUE,
    F_COLLECT,
    F_DONE
  } fill_state_e;
endpackage

// File: rtl/rdpath_fifo.sv
module rdpath_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count
);
  // DEPTH is a power of two so the pointers wrap on their own.
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  always_comb begin
    wr_ptr_d = wr_en ? wr_ptr_q + 1'b1 : wr_ptr_q;
    rd_ptr_d = rd_en ? rd_ptr_q + 1'b1 : rd_ptr_q;
    unique case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_ptr_q] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_ptr_q];
  assign count   = cnt_q;
endmodule

// File: rtl/rdpath_fill.sv
module rdpath_fill
  import rdpath_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned MAX_QUADS = 8,
  parameter int unsigned FCW       = 6,
  localparam int unsigned BPW     = DATA_W / 8,
  localparam int unsigned WPQ     = QUAD_BYTES / BPW,
  localparam int unsigned BEAT_W  = $clog2(WPQ),
  localparam int unsigned BYTE_SH = $clog2(BPW),
  localparam int unsigned QW      = $clog2(MAX_QUADS + 1),
  localparam int unsigned CNT_W   = $clog2(MAX_QUADS * WPQ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_burst,
  input  logic [LEN_W-1:0]  req_bytes,
  input  logic [FCW-1:0]    fifo_free,
  input  logic              mc_rd_valid,
  output logic              cmd_pending,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              fifo_wr,
  output logic [CNT_W-1:0]  burst_count
);
  fill_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [QW-1:0]     quads_q, quads_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BEAT_W-1:0] pick_q, pick_d;
  logic              single_q, single_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic [LEN_W-1:0]  raw_quads;
  logic [QW-1:0]     req_quads;
  logic [FCW-1:0]    req_words;
  logic              accept;
  logic              last_beat;
  logic              ctx_en, beat_en, cnt_en;
  logic [BYTE_SH-1:0] unused_lo;

  assign unused_lo = req_addr[BYTE_SH-1:0];

  // Length in bytes -> number of 16-byte commands, clamped to [1, MAX_QUADS].
  assign raw_quads = req_bytes >> QUAD_LSB;
  always_comb begin
    if (!req_burst || raw_quads == '0) begin
      req_quads = QW'(1);
    end else if (raw_quads > LEN_W'(MAX_QUADS)) begin
      req_quads = QW'(MAX_QUADS);
    end else begin
      req_quads = QW'(raw_quads);
    end
    req_words = req_burst ? FCW'(req_quads) * FCW'(WPQ) : FCW'(1);
  end

  assign accept    = (state_q == F_IDLE) && req_valid && (fifo_free >= req_words);
  assign last_beat = (beat_q == BEAT_W'(WPQ - 1));
  assign fifo_wr   = (state_q == F_COLLECT) && mc_rd_valid &&
                     (!single_q || beat_q == pick_q);

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    quads_d  = quads_q;
    beat_d   = beat_q;
    pick_d   = pick_q;
    single_d = single_q;
    cnt_d    = cnt_q;
    ctx_en   = 1'b0;
    beat_en  = 1'b0;
    cnt_en   = 1'b0;
    unique case (state_q)
      F_IDLE: begin
        if (accept) begin
          ctx_en   = 1'b1;
          cnt_en   = 1'b1;
          single_d = !req_burst;
          pick_d   = req_addr[QUAD_LSB-1 -: BEAT_W];
          addr_d   = {req_addr[ADDR_W-1:QUAD_LSB], {QUAD_LSB{1'b0}}};
          quads_d  = req_quads;
          cnt_d    = '0;
          state_d  = F_ANNOUNCE;
        end
      end
      F_ANNOUNCE: state_d = F_ISSUE;
      F_ISSUE: begin
        beat_en = 1'b1;
        beat_d  = '0;
        state_d = F_COLLECT;
      end
      F_COLLECT: begin
        if (mc_rd_valid) begin
          beat_en = 1'b1;
          if (fifo_wr) begin
            cnt_en = 1'b1;
            cnt_d  = cnt_q + 1'b1;
          end
          if (last_beat) begin
            ctx_en  = 1'b1;
            beat_d  = '0;
            addr_d  = addr_q + ADDR_W'(QUAD_BYTES);
            quads_d = quads_q - 1'b1;
            state_d = (quads_q == QW'(1)) ? F_DONE : F_ANNOUNCE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      F_DONE: begin
        if (!req_valid) state_d = F_IDLE;
      end
      default: state_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= F_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      quads_q  <= '0;
      pick_q   <= '0;
      single_q <= 1'b0;
    end else if (ctx_en) begin
      addr_q   <= addr_d;
      quads_q  <= quads_d;
      pick_q   <= pick_d;
      single_q <= single_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cmd_pending = (state_q == F_ANNOUNCE);
  assign cmd_valid   = (state_q == F_ISSUE);
  assign cmd_addr    = addr_q;
  assign burst_count = cnt_q;
endmodule

// File: rtl/rdpath_drain.sv
module rdpath_drain #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     fifo_count,
  input  logic [DATA_W-1:0] fifo_head,
  output logic              fifo_pop,
  output logic              rd_ack,
  output logic [DATA_W-1:0] bus_rd_data
);
  logic [DATA_W-1:0] data_q;
  logic              load_en;

  // Stalls only on an empty FIFO; the bus side takes one word per cycle.
  assign load_en  = (fifo_count != '0);
  assign fifo_pop = load_en;
  assign rd_ack   = load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_en) begin
      data_q <= fifo_head;
    end
  end

  assign bus_rd_data = data_q;
endmodule

// File: rtl/rdpath_ctrl.sv
module rdpath_ctrl
  import rdpath_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned MAX_QUADS  = 8,
  localparam int unsigned WPQ   = QUAD_BYTES / (DATA_W / 8),
  localparam int unsigned CNT_W = $clog2(MAX_QUADS * WPQ + 1),
  localparam int unsigned FCW   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd_nwr,
  input  logic              bus_rd_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_burst,
  input  logic [LEN_W-1:0]  bus_burst_bytes,
  input  logic              mc_addr_almost_full,
  input  logic              mc_rd_valid,
  input  logic [DATA_W-1:0] mc_rd_data,
  output logic              cmd_pending,
  output logic              mc_cmd_valid,
  output logic [ADDR_W-1:0] mc_cmd_addr,
  output logic              rd_ack,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic [CNT_W-1:0]  burst_count
);
  logic              req_valid;
  logic              fifo_wr, fifo_pop;
  logic [DATA_W-1:0] fifo_head;
  logic [FCW-1:0]    fifo_count, fifo_free;
  logic              unused_af;

  assign unused_af = mc_addr_almost_full;
  assign req_valid = bus_sel & bus_rd_nwr & bus_rd_req;
  assign fifo_free = FCW'(FIFO_DEPTH) - fifo_count;

  rdpath_fill #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .MAX_QUADS(MAX_QUADS), .FCW(FCW)
  ) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (bus_addr),
    .req_burst   (bus_burst),
    .req_bytes   (bus_burst_bytes),
    .fifo_free   (fifo_free),
    .mc_rd_valid (mc_rd_valid),
    .cmd_pending (cmd_pending),
    .cmd_valid   (mc_cmd_valid),
    .cmd_addr    (mc_cmd_addr),
    .fifo_wr     (fifo_wr),
    .burst_count (burst_count)
  );

  rdpath_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fifo_wr),
    .wr_data (mc_rd_data),
    .rd_en   (fifo_pop),
    .rd_data (fifo_head),
    .count   (fifo_count)
  );

  rdpath_drain #(.DATA_W(DATA_W), .CW(FCW)) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_count  (fifo_count),
    .fifo_head   (fifo_head),
    .fifo_pop    (fifo_pop),
    .rd_ack      (rd_ack),
    .bus_rd_data (bus_rd_data)
  );
endmodule

// File: rtl/rdpath_ctrl_chk.sv
module rdpath_ctrl_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_pending,
  input logic              mc_cmd_valid,
  input logic [ADDR_W-1:0] mc_cmd_addr,
  input logic              rd_ack,
  input logic [DATA_W-1:0] bus_rd_data,
  input logic [CNT_W-1:0]  burst_count
);
  AST_CMD_ANNOUNCED: assert property (@(posedge clk) disable iff (!rst_n)
    mc_cmd_valid |-> $past(cmd_pending)); // R3
  AST_NOTICE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pending |=> mc_cmd_valid); // R3
  AST_CMD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mc_cmd_valid |=> !mc_cmd_valid); // R3
  AST_CMD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mc_cmd_valid |-> (mc_cmd_addr[3:0] == 4'h0)); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_ack) |-> $stable(bus_rd_data)); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_count != $past(burst_count)) |->
      (burst_count == $past(burst_count) + 1'b1 || burst_count == '0)); // R9
endmodule

bind rdpath_ctrl rdpath_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_pending  (cmd_pending),
  .mc_cmd_valid (mc_cmd_valid),
  .mc_cmd_addr  (mc_cmd_addr),
  .rd_ack       (rd_ack),
  .bus_rd_data  (bus_rd_data),
  .burst_count  (burst_count)
);

// File: tb/rdpath_ctrl_bench.sv
module rdpath_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_rd_nwr, bus_rd_req, bus_burst;
  logic [31:0] bus_addr;
  logic [7:0]  bus_burst_bytes;
  logic        mc_addr_almost_full, mc_rd_valid;
  logic [31:0] mc_rd_data;
  logic        cmd_pending, mc_cmd_valid, rd_ack;
  logic [31:0] mc_cmd_addr, bus_rd_data;
  logic [5:0]  burst_count;

  rdpath_ctrl u_rdpath_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd_nwr(bus_rd_nwr),
    .bus_rd_req(bus_rd_req), .bus_addr(bus_addr), .bus_burst(bus_burst),
    .bus_burst_bytes(bus_burst_bytes), .mc_addr_almost_full(mc_addr_almost_full),
    .mc_rd_valid(mc_rd_valid), .mc_rd_data(mc_rd_data), .cmd_pending(cmd_pending),
    .mc_cmd_valid(mc_cmd_valid), .mc_cmd_addr(mc_cmd_addr), .rd_ack(rd_ack),
    .bus_rd_data(bus_rd_data), .burst_count(burst_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] cmd_q[$];
  logic [31:0] data_q[$];
  int          ack_cyc_q[$];
  int          beat_cyc_q[$];
  int          pend_cnt = 0;
  int          ann_err = 0;
  bit          prev_pend = 0;
  bit          prev_ack = 0;
  bit          gap_en = 0;
  int          stray_req_n = 0;
  int          stray_done_n = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: observes ports at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_ack) data_q.push_back(bus_rd_data);
        if (mc_cmd_valid) begin
          cmd_q.push_back(mc_cmd_addr);
          if (!prev_pend) ann_err++;
        end
        if (cmd_pending) pend_cnt++;
        if (rd_ack) ack_cyc_q.push_back(cyc);
        prev_pend = cmd_pending;
        prev_ack  = rd_ack;
      end
    end
  end

  // Memory controller model: four beats per command after two cycles.
  initial begin
    logic [31:0] a;
    mc_rd_valid = 1'b0;
    mc_rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mc_cmd_valid) begin
        a = mc_cmd_addr;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
          if (gap_en && i == 2) begin
            mc_rd_valid = 1'b0;
            @(negedge clk);
          end
          mc_rd_valid = 1'b1;
          mc_rd_data  = mem_word(a + 32'(4 * i));
          beat_cyc_q.push_back(cyc);
          @(negedge clk);
        end
        mc_rd_valid = 1'b0;
      end else if (stray_req_n != stray_done_n) begin
        mc_rd_valid = 1'b1;
        mc_rd_data  = 32'hDEAD_BEEF;
        @(negedge clk);
        mc_rd_valid = 1'b0;
        stray_done_n++;
      end
    end
  end

  task automatic do_read(input logic [31:0] addr, input bit burst,
                         input logic [7:0] bytes, input int hold, input string tag);
    int c0 = cmd_q.size();
    int d0 = data_q.size();
    int a0 = ack_cyc_q.size();
    int b0 = beat_cyc_q.size();
    int p0 = pend_cnt;
    int nq;
    int words;
    logic [31:0] base;
    logic [31:0] ea[$];
    logic [31:0] ed[$];
    base = addr & 32'hFFFF_FFF0;
    if (!burst) begin
      nq = 1;
      ea.push_back(base);
      ed.push_back(mem_word(addr & ~32'h3));
    end else begin
      nq = int'(bytes) / 16;
      if (nq == 0) nq = 1;
      if (nq > 8) nq = 8;
      for (int q = 0; q < nq; q++) begin
        ea.push_back(base + 32'(16 * q));
        for (int i = 0; i < 4; i++) ed.push_back(mem_word(base + 32'(16 * q + 4 * i)));
      end
    end
    words = ed.size();
    @(negedge clk);
    bus_sel = 1'b1; bus_rd_nwr = 1'b1; bus_rd_req = 1'b1;
    bus_addr = addr; bus_burst = burst; bus_burst_bytes = bytes;
    for (int w = 0; w < 2000 && (data_q.size() - d0) < words; w++) @(negedge clk);
    if (hold > 0) begin
      int cq = cmd_q.size();
      int pq = pend_cnt;
      repeat (hold) @(negedge clk);
      chk(pend_cnt == pq && cmd_q.size() == cq, {tag, " R11 no new command while request held"},
          64'(pend_cnt - pq), 64'd0);
    end
    bus_rd_req = 1'b0; bus_sel = 1'b0;
    repeat (4) @(negedge clk);
    chk(cmd_q.size() - c0 == nq, {tag, " R4 command count"}, 64'(cmd_q.size() - c0), 64'(nq));
    for (int k = 0; k < nq; k++) begin
      if (c0 + k < cmd_q.size())
        chk(cmd_q[c0 + k] == ea[k], {tag, " R4 command address"}, 64'(cmd_q[c0 + k]), 64'(ea[k]));
    end
    chk(pend_cnt - p0 == nq, {tag, " R3 one notice per command"}, 64'(pend_cnt - p0), 64'(nq));
    chk(ack_cyc_q.size() - a0 == words, {tag, " R8 acknowledge count"},
        64'(ack_cyc_q.size() - a0), 64'(words));
    for (int k = 0; k < words; k++) begin
      if (d0 + k < data_q.size())
        chk(data_q[d0 + k] == ed[k], {tag, " R7 returned word in order"},
            64'(data_q[d0 + k]), 64'(ed[k]));
      else
        chk(1'b0, {tag, " R7 returned word missing"}, 64'(k), 64'(words));
    end
    chk(burst_count == 6'(words), {tag, " R9 final burst count"}, 64'(burst_count), 64'(words));
    if (burst && ack_cyc_q.size() > a0 && beat_cyc_q.size() > b0)
      chk(ack_cyc_q[a0] == beat_cyc_q[b0] + 1, {tag, " R8 first acknowledge latency"},
          64'(ack_cyc_q[a0] - beat_cyc_q[b0]), 64'd1);
    if (burst && !gap_en && ack_cyc_q.size() >= a0 + 4)
      chk(ack_cyc_q[a0 + 3] == ack_cyc_q[a0] + 3, {tag, " R8 back-to-back acknowledges"},
          64'(ack_cyc_q[a0 + 3] - ack_cyc_q[a0]), 64'd3);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!cmd_pending && !mc_cmd_valid && !rd_ack, "R1 strobes low in reset",
        64'({cmd_pending, mc_cmd_valid, rd_ack}), 64'd0);
    chk(burst_count == '0 && bus_rd_data == '0, "R1 count and data zero in reset",
        64'({burst_count, bus_rd_data}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_pending && !mc_cmd_valid && !rd_ack && burst_count == '0,
        "R1 quiet after reset release", 64'({cmd_pending, mc_cmd_valid, rd_ack, burst_count}), 64'd0);
  endtask

  task automatic t_bad_requests;
    int p0 = pend_cnt;
    logic [2:0] combos [3] = '{3'b011, 3'b101, 3'b110};
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      {bus_sel, bus_rd_nwr, bus_rd_req} = combos[c];
      bus_addr = 32'h0000_0040; bus_burst = 1'b1; bus_burst_bytes = 8'd32;
      repeat (4) @(negedge clk);
    end
    {bus_sel, bus_rd_nwr, bus_rd_req} = 3'b000;
    repeat (2) @(negedge clk);
    chk(pend_cnt == p0, "R2 incomplete request ignored", 64'(pend_cnt - p0), 64'd0);
  endtask

  task automatic t_stray_strobe;
    int a0 = ack_cyc_q.size();
    logic [5:0] bc0 = burst_count;
    stray_req_n++;
    repeat (6) @(negedge clk);
    chk(ack_cyc_q.size() == a0, "R6 stray strobe gives no acknowledge",
        64'(ack_cyc_q.size() - a0), 64'd0);
    chk(burst_count == bc0, "R6 stray strobe leaves count", 64'(burst_count), 64'(bc0));
  endtask

  initial begin
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_rd_nwr = 1'b0; bus_rd_req = 1'b0; bus_burst = 1'b0;
    bus_addr = '0; bus_burst_bytes = '0; mc_addr_almost_full = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_bad_requests();
    do_read(32'h0000_1000, 1'b0, 8'd0, 0, "R5 single idx0");
    do_read(32'h0000_2034, 1'b0, 8'd0, 0, "R5 single idx1");
    do_read(32'h0000_20AC, 1'b0, 8'd4, 0, "R5 single idx3");
    do_read(32'h1000_0038, 1'b1, 8'd64, 0, "R4 misaligned 64B");
    do_read(32'h0000_3000, 1'b1, 8'd128, 0, "R4 max 128B");
    do_read(32'h0000_4010, 1'b1, 8'd200, 0, "R4 clamp 200B");
    do_read(32'h0000_5000, 1'b1, 8'd0, 0, "R4 zero length");
    do_read(32'h0000_6000, 1'b1, 8'd40, 0, "R4 remainder dropped");
    gap_en = 1'b1;
    do_read(32'h0000_7000, 1'b1, 8'd48, 0, "R6 beat gaps");
    gap_en = 1'b0;
    t_stray_strobe();
    mc_addr_almost_full = 1'b1;
    do_read(32'h0000_8000, 1'b1, 8'd128, 0, "R10 almost full held");
    mc_addr_almost_full = 1'b0;
    do_read(32'h0000_9020, 1'b1, 8'd32, 6, "R11 request held");
    do_read(32'h0000_A008, 1'b0, 8'd0, 0, "R9 count restarts");
    chk(ann_err == 0, "R3 every command preceded by notice", 64'(ann_err), 64'd0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule